// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends characters as asynchronous serial frames. The host writes a character into a parallel holding register. The frame engine copies it into an internal shifter that the host cannot reach. While one character shifts out, the host can load the next one. When the shifter finishes the stop bit and a character is waiting, the next frame starts on the following bit boundary with no idle gap.

A frame is one low start bit, then a data field sent least significant bit first, then one high stop bit. The field is 8 or 9 bits wide. When parity is on, the top position of the field carries the parity bit in place of a data bit, so the frame length does not change. A programmable divisor sets the bit period to 32 times the divisor in system clocks, and a divisor of zero halts transmission.

The output stage drives the line push-pull, or in a wired-OR mode it drives only low and releases the line for highs, so several transmitters can share one wire. When the transmitter is disabled, a frame already on the wire still completes before the pin is released.

Top module: `sertx_dbuf`

## Requirements
- R1: A frame is a start bit of 0, then the field least significant bit first, then a stop bit of 1. The field is 8 bits when `nine_bit`=0 and 9 bits when `nine_bit`=1. Write-data bits above the field are ignored.
- R2: With `par_en`=1, the field's top position (bit 7 or bit 8) carries parity over the field's lower bits instead of a data bit. `par_odd`=0 makes the count of ones in the field even, and `par_odd`=1 makes it odd.
- R3: Every bit, the start bit included, lasts exactly 32 × `divisor` clock cycles.
- R4: While `divisor` is 0, no character moves into the shifter, the line stays at 1 and `hold_empty` stays 0. Once the divisor becomes nonzero, the held character is sent.
- R5: A character written while a frame is shifting is sent immediately after that frame's stop bit, with no idle time between the frames.
- R6: `hold_empty` goes to 0 after a write and returns to 1 when the character moves into the shifter. If a write lands in the same cycle as that transfer, `hold_empty` stays 0 and the newly written character is the next one sent.
- R7: `tx_done` is 1 only when the shifter is idle and the holding register is empty. It is 0 from a write until the last queued stop bit has ended.
- R8: While `tx_enable`=0, no character moves into the shifter. A frame in progress when `tx_enable` falls completes unchanged with the pin driven. After it, `txd_oe`=0 and `txd_out`=1.
- R9: With `wired_or`=1, `txd_oe` is 1 only while the transmitted level is 0. With `wired_or`=0, `txd_oe` is 1 whenever the transmitter is enabled or a frame is in progress, and idle drives a 1.
- R10: During and right after reset, with `tx_enable`=0: `hold_empty`=1, `tx_done`=1, `txd_out`=1 and `txd_oe`=0.
- R11: A write while the holding register is full replaces the waiting character; only the last one written is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W (9) | Character to send |
| divisor | input | DIV_W (13) | Bit period is 32 × divisor clocks; 0 halts |
| tx_enable | input | 1 | Transmitter enable |
| nine_bit | input | 1 | Field width: 0 = 8 bits, 1 = 9 bits |
| par_en | input | 1 | Parity replaces the field's top bit |
| par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| wired_or | input | 1 | 1 = drive low only, 0 = push-pull |
| hold_empty | output | 1 | Holding register can take a character |
| tx_done | output | 1 | Shifter idle and holding register empty |
| txd_out | output | 1 | Serial line level (1 when released) |
| txd_oe | output | 1 | Pin actively driven |

## Verification
Two functions can coincide in one cycle. The first is a host write to the holding register in the same cycle that the holding register transfers into the shifter. The bench provokes it by writing on two consecutive clock edges from idle, so that the second write meets the first character's transfer. It then requires `hold_empty` to stay 0 and both characters to appear in order. The second coincidence is the end of a stop bit meeting a waiting character: this must reload the shifter on the same edge. The bench judges it by counting cycles from the middle of the stop bit to the next start edge, which must be exactly half a bit. The same collision while a frame is busy, with two writes in a row, shows that only the later character is sent.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_SHIFT = 1'b1
   } sertx_state_e;

   typedef struct packed {
      logic nine;
      logic par_en;
      logic par_odd;
   } sertx_fmt_t;

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
   parameter int DIV_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   input  logic             run,
   input  logic             restart,
   output logic             sub_tick
);
   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   logic [DIV_W-1:0] cnt;
   logic             div_ok;

   assign div_ok   = |divisor;
   assign sub_tick = run && div_ok && (cnt == divisor - ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart || !run || sub_tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + ONE;
      end
   end

   // R4: a zero divisor never yields a prescaler pulse
   a_r4_no_tick_div0 : assert property (@(posedge clk) disable iff (!rst_n)
      (divisor == '0) |-> !sub_tick);

   // R3: pulses are spaced by the divisor, so never back to back above 1
   a_r3_tick_spacing : assert property (@(posedge clk) disable iff (!rst_n)
      (sub_tick && divisor > ONE) |=> (!sub_tick || divisor != $past(divisor)));

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else if (wr_en) begin
         full <= 1'b1;
         data <= wr_data;
      end else if (take) begin
         full <= 1'b0;
      end
   end

   // R6: a transfer without a new write leaves the register empty
   a_r6_empty_after_take : assert property (@(posedge clk) disable iff (!rst_n)
      (take && !wr_en) |=> !full);

   // R6: the shifter only takes a character that is present
   a_r6_take_needs_full : assert property (@(posedge clk) disable iff (!rst_n)
      take |-> full);

   // R11: the latest write always wins the holding register
   a_r11_last_write_wins : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (full && data == $past(wr_data)));

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
   import sertx_pkg::*;
#(
   parameter int DATA_W = 9,
   parameter int OVS    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sub_tick,
   input  logic              hold_full,
   input  logic [DATA_W-1:0] hold_data,
   input  logic              tx_enable,
   input  logic              div_ok,
   input  sertx_fmt_t        fmt,
   output logic              take,
   output logic              busy,
   output logic              line
);
   localparam int SR_W  = DATA_W + 2;
   localparam int CNT_W = $clog2(SR_W + 1);
   localparam int TMR_W = $clog2(OVS);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [TMR_W-1:0] TMR_ONE = TMR_W'(1);
   localparam logic [TMR_W-1:0] TMR_TOP = TMR_W'(OVS - 1);

   sertx_state_e      state;
   logic [SR_W-1:0]   sr;
   logic [CNT_W-1:0]  bitcnt;
   logic [TMR_W-1:0]  tmr;
   logic              tmr_wrap;
   logic              bit_tick;
   logic              last_bit;
   logic              can_load;
   logic [SR_W-1:0]   frame_n;
   logic [CNT_W-1:0]  nbits_n;

   // bit timer end detection: a power-of-two oversample uses an all-ones test
   generate
      if ((OVS & (OVS - 1)) == 0) begin : g_pow2
         assign tmr_wrap = &tmr;
      end else begin : g_cmp
         assign tmr_wrap = (tmr == TMR_TOP);
      end
   endgenerate

   // frame image: start at bit 0, field above it, ones (stop/fill) beyond
   always_comb begin
      int   fw;
      logic par;
      fw      = fmt.nine ? DATA_W : DATA_W - 1;
      par     = fmt.par_odd;
      frame_n = '1;
      frame_n[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < fw) begin
            if (fmt.par_en && i == fw - 1) begin
               frame_n[i+1] = par;
            end else begin
               frame_n[i+1] = hold_data[i];
            end
            if (i < fw - 1) begin
               par = par ^ hold_data[i];
            end
         end
      end
      nbits_n = CNT_W'(fw + 2);
   end

   assign busy     = (state == ST_SHIFT);
   assign bit_tick = sub_tick && tmr_wrap;
   assign last_bit = busy && bit_tick && (bitcnt == CNT_ONE);
   assign can_load = hold_full && tx_enable && div_ok;
   assign take     = can_load && (!busy || last_bit);
   assign line     = sr[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         sr     <= '1;
         bitcnt <= '0;
         tmr    <= '0;
      end else if (take) begin
         state  <= ST_SHIFT;
         sr     <= frame_n;
         bitcnt <= nbits_n;
         tmr    <= '0;
      end else if (busy && sub_tick) begin
         tmr <= bit_tick ? '0 : tmr + TMR_ONE;
         if (bit_tick) begin
            if (bitcnt == CNT_ONE) begin
               state  <= ST_IDLE;
               sr     <= '1;
               bitcnt <= '0;
            end else begin
               sr     <= {1'b1, sr[SR_W-1:1]};
               bitcnt <= bitcnt - CNT_ONE;
            end
         end
      end
   end

   // R8: a disabled idle engine stays idle
   a_r8_idle_when_disabled : assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !tx_enable) |=> !busy);

   // R4: a zero divisor keeps the idle engine idle
   a_r4_idle_div0 : assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !div_ok) |=> !busy);

   // R1: every frame begins with a low start bit
   a_r1_start_low : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (line == 1'b0));

   // R1: the remaining-bit count stays inside the frame length
   a_r1_count_range : assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (bitcnt != '0 && bitcnt <= CNT_W'(SR_W)));

   // R5: a waiting character follows the stop bit without a gap
   a_r5_seamless_reload : assert property (@(posedge clk) disable iff (!rst_n)
      (last_bit && can_load) |=> (busy && line == 1'b0));

endmodule

// File: rtl/sertx_pad.sv
module sertx_pad (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_enable,
   input  logic busy,
   input  logic line,
   input  logic wired_or,
   output logic txd_out,
   output logic txd_oe
);
   logic active;

   assign active  = tx_enable || busy;
   assign txd_out = active ? line : 1'b1;
   assign txd_oe  = active && (!wired_or || !line);

   // R9: wired-OR mode never drives a high level
   a_r9_wired_low_only : assert property (@(posedge clk) disable iff (!rst_n)
      wired_or |-> !(txd_oe && txd_out));

   // R8: with nothing in flight and the enable off, the pin is released high
   a_r8_released : assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_enable && !busy) |-> (!txd_oe && txd_out));

endmodule

// File: rtl/sertx_dbuf.sv
module sertx_dbuf
   import sertx_pkg::*;
#(
   parameter int DATA_W = 9,
   parameter int DIV_W  = 13,
   parameter int OVS    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DIV_W-1:0]  divisor,
   input  logic              tx_enable,
   input  logic              nine_bit,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              wired_or,
   output logic              hold_empty,
   output logic              tx_done,
   output logic              txd_out,
   output logic              txd_oe
);
   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("sertx_dbuf: DATA_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div_w
         $error("sertx_dbuf: DIV_W must be at least 1");
      end
      if (OVS < 2) begin : g_bad_ovs
         $error("sertx_dbuf: OVS must be at least 2");
      end
   endgenerate

   logic              sub_tick;
   logic              take;
   logic              busy;
   logic              line;
   logic              hold_full;
   logic [DATA_W-1:0] hold_data;
   sertx_fmt_t        fmt;

   assign fmt = '{nine: nine_bit, par_en: par_en, par_odd: par_odd};

   sertx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk      (clk),
      .rst_n    (rst_n),
      .divisor  (divisor),
      .run      (busy),
      .restart  (take),
      .sub_tick (sub_tick)
   );

   sertx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .take    (take),
      .full    (hold_full),
      .data    (hold_data)
   );

   sertx_shift #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sub_tick  (sub_tick),
      .hold_full (hold_full),
      .hold_data (hold_data),
      .tx_enable (tx_enable),
      .div_ok    (|divisor),
      .fmt       (fmt),
      .take      (take),
      .busy      (busy),
      .line      (line)
   );

   sertx_pad u_pad (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_enable (tx_enable),
      .busy      (busy),
      .line      (line),
      .wired_or  (wired_or),
      .txd_out   (txd_out),
      .txd_oe    (txd_oe)
   );

   assign hold_empty = !hold_full;
   assign tx_done    = !busy && !hold_full;

   // R7: completion implies nothing is queued and the line is idle high
   a_r7_done_is_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> (hold_empty && txd_out));

endmodule

// File: tb/sertx_dbuf_tb.sv
module sertx_dbuf_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [8:0]  wr_data;
   logic [12:0] divisor;
   logic        tx_enable, nine_bit, par_en, par_odd, wired_or;
   logic        hold_empty, tx_done, txd_out, txd_oe;

   int n_chk  = 0;
   int n_fail = 0;
   bit ended  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sertx_dbuf u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .divisor(divisor), .tx_enable(tx_enable), .nine_bit(nine_bit),
      .par_en(par_en), .par_odd(par_odd), .wired_or(wired_or),
      .hold_empty(hold_empty), .tx_done(tx_done),
      .txd_out(txd_out), .txd_oe(txd_oe)
   );

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   function automatic int frame_len(input logic nine);
      return nine ? 11 : 10;
   endfunction

   function automatic logic [15:0] exp_frame(input logic [8:0] d, input logic nine,
                                             input logic pe, input logic po);
      int          fw;
      logic [8:0]  f;
      logic        p;
      logic [15:0] r;
      fw = nine ? 9 : 8;
      f  = nine ? d : {1'b0, d[7:0]};
      if (pe) begin
         p = po;
         for (int i = 0; i < fw - 1; i++) p = p ^ f[i];
         f[fw-1] = p;
      end
      r = '0;
      for (int i = 0; i < fw; i++) r[i+1] = f[i];
      r[fw+1] = 1'b1;
      return r;
   endfunction

   task automatic write1(input logic [8:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic write2(input logic [8:0] a, input logic [8:0] b);
      @(negedge clk); wr_en = 1'b1; wr_data = a;
      @(negedge clk); wr_data = b;
      @(negedge clk); wr_en = 1'b0;
   endtask

   // waits for a start edge, then samples each bit at its centre
   task automatic capture(input int div, input int nb,
                          output logic [15:0] bits, output logic [15:0] oes);
      int w = 0;
      bits = '0; oes = '0;
      while (txd_out !== 1'b0 && w < 5000) begin @(negedge clk); w++; end
      repeat (16*div) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         bits[i] = txd_out;
         oes[i]  = txd_oe;
         if (i < nb - 1) repeat (32*div) @(negedge clk);
      end
   endtask

   function automatic logic [15:0] mask(input int nb);
      return 16'((32'h1 << nb) - 1);
   endfunction

   task automatic t_reset();
      rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; divisor = 13'd1;
      tx_enable = 1'b0; nine_bit = 1'b0; par_en = 1'b0; par_odd = 1'b0; wired_or = 1'b0;
      repeat (4) @(negedge clk);
      check(hold_empty && tx_done && txd_out && !txd_oe, "R10 in reset",
            {hold_empty, tx_done, txd_out, txd_oe}, 4'b1110);
      rst_n = 1'b1;
      @(negedge clk);
      check(hold_empty && tx_done && txd_out && !txd_oe, "R10 after reset",
            {hold_empty, tx_done, txd_out, txd_oe}, 4'b1110);
      tx_enable = 1'b1;
   endtask

   task automatic t_format(input logic [8:0] d, input logic nine, input logic pe,
                           input logic po, input string tag);
      logic [15:0] b, o, e;
      int nb;
      nb = frame_len(nine);
      @(negedge clk); nine_bit = nine; par_en = pe; par_odd = po;
      write1(d);
      check(!tx_done, "R7 busy after write", tx_done, 0);
      capture(1, nb, b, o);
      e = exp_frame(d, nine, pe, po);
      check((b & mask(nb)) == e, tag, b, e);
      check((o & mask(nb)) == mask(nb), "R9 push-pull drives", o, mask(nb));
      repeat (40) @(negedge clk);
      check(tx_done && hold_empty, "R7 done after stop", {tx_done, hold_empty}, 2'b11);
      check(txd_oe && txd_out, "R9 push-pull idle high driven", {txd_oe, txd_out}, 2'b11);
   endtask

   task automatic t_rate();
      logic [15:0] b, o;
      int cnt = 0;
      @(negedge clk); divisor = 13'd2; nine_bit = 1'b0; par_en = 1'b0;
      write1(9'h0FF);
      while (txd_out !== 1'b0 && cnt < 5000) begin @(negedge clk); cnt++; end
      cnt = 0;
      while (txd_out === 1'b0 && cnt < 5000) begin @(negedge clk); cnt++; end
      check(cnt == 64, "R3 start bit length at divisor 2", cnt, 64);
      repeat (600) @(negedge clk);
      write1(9'h05A);
      capture(2, 10, b, o);
      check((b & mask(10)) == exp_frame(9'h05A, 1'b0, 1'b0, 1'b0), "R3 frame at divisor 2",
            b, exp_frame(9'h05A, 1'b0, 1'b0, 1'b0));
      repeat (100) @(negedge clk);
      divisor = 13'd1;
   endtask

   task automatic t_div0();
      logic [15:0] b, o;
      @(negedge clk); divisor = 13'd0;
      write1(9'h0C3);
      repeat (200) @(negedge clk);
      check(txd_out === 1'b1 && !hold_empty && !tx_done, "R4 halted at divisor 0",
            {txd_out, hold_empty, tx_done}, 3'b100);
      divisor = 13'd1;
      capture(1, 10, b, o);
      check((b & mask(10)) == exp_frame(9'h0C3, 1'b0, 1'b0, 1'b0), "R4 resumes",
            b, exp_frame(9'h0C3, 1'b0, 1'b0, 1'b0));
      repeat (40) @(negedge clk);
   endtask

   task automatic t_back_to_back();
      logic [15:0] b1, o1, b2, o2;
      int gap = 0;
      write1(9'h011);
      fork
         capture(1, 10, b1, o1);
         begin
            repeat (50) @(negedge clk);
            write1(9'h0E7);
            check(!hold_empty, "R6 full while shifting", hold_empty, 0);
         end
      join
      while (txd_out !== 1'b0 && gap < 5000) begin @(negedge clk); gap++; end
      check(gap == 16, "R5 no gap between frames", gap, 16);
      capture(1, 10, b2, o2);
      check((b1 & mask(10)) == exp_frame(9'h011, 1'b0, 1'b0, 1'b0), "R5 first frame",
            b1, exp_frame(9'h011, 1'b0, 1'b0, 1'b0));
      check((b2 & mask(10)) == exp_frame(9'h0E7, 1'b0, 1'b0, 1'b0), "R5 second frame",
            b2, exp_frame(9'h0E7, 1'b0, 1'b0, 1'b0));
      repeat (40) @(negedge clk);
   endtask

   task automatic t_same_cycle();
      logic [15:0] b1, o1, b2, o2;
      write2(9'h0A1, 9'h03C);
      check(!hold_empty, "R6 write meets transfer", hold_empty, 0);
      capture(1, 10, b1, o1);
      capture(1, 10, b2, o2);
      check((b1 & mask(10)) == exp_frame(9'h0A1, 1'b0, 1'b0, 1'b0), "R6 first char",
            b1, exp_frame(9'h0A1, 1'b0, 1'b0, 1'b0));
      check((b2 & mask(10)) == exp_frame(9'h03C, 1'b0, 1'b0, 1'b0), "R6 second char",
            b2, exp_frame(9'h03C, 1'b0, 1'b0, 1'b0));
      repeat (40) @(negedge clk);
   endtask

   task automatic t_overwrite();
      logic [15:0] b1, o1, b2, o2;
      write1(9'h0F0);
      fork
         capture(1, 10, b1, o1);
         begin
            repeat (50) @(negedge clk);
            write2(9'h055, 9'h0AA);
         end
      join
      capture(1, 10, b2, o2);
      check((b2 & mask(10)) == exp_frame(9'h0AA, 1'b0, 1'b0, 1'b0), "R11 last write sent",
            b2, exp_frame(9'h0AA, 1'b0, 1'b0, 1'b0));
      repeat (40) @(negedge clk);
      check(tx_done, "R11 nothing else queued", tx_done, 1);
   endtask

   task automatic t_enable();
      logic [15:0] b1, o1, b2, o2;
      write1(9'h0B4);
      fork
         capture(1, 10, b1, o1);
         begin
            repeat (50) @(negedge clk);
            tx_enable = 1'b0;
            write1(9'h04D);
         end
      join
      check((b1 & mask(10)) == exp_frame(9'h0B4, 1'b0, 1'b0, 1'b0), "R8 frame completes",
            b1, exp_frame(9'h0B4, 1'b0, 1'b0, 1'b0));
      check((o1 & mask(10)) == mask(10), "R8 pin driven to frame end", o1, mask(10));
      repeat (40) @(negedge clk);
      check(!txd_oe && txd_out, "R8 pin released", {txd_oe, txd_out}, 2'b01);
      check(!hold_empty, "R8 no transfer while disabled", hold_empty, 0);
      check(!tx_done, "R7 pending char blocks done", tx_done, 0);
      tx_enable = 1'b1;
      capture(1, 10, b2, o2);
      check((b2 & mask(10)) == exp_frame(9'h04D, 1'b0, 1'b0, 1'b0), "R8 sent after enable",
            b2, exp_frame(9'h04D, 1'b0, 1'b0, 1'b0));
      repeat (40) @(negedge clk);
   endtask

   task automatic t_wired();
      logic [15:0] b, o, e;
      @(negedge clk); wired_or = 1'b1; nine_bit = 1'b0; par_en = 1'b0;
      write1(9'h096);
      capture(1, 10, b, o);
      e = exp_frame(9'h096, 1'b0, 1'b0, 1'b0);
      check((b & mask(10)) == e, "R9 wired frame level", b, e);
      check((o & mask(10)) == (~e & mask(10)), "R9 drive only lows", o, ~e & mask(10));
      repeat (40) @(negedge clk);
      check(!txd_oe && txd_out, "R9 wired idle released", {txd_oe, txd_out}, 2'b01);
      wired_or = 1'b0;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
      finish_run();
   end

   initial begin
      t_reset();
      t_format(9'h1A5, 1'b0, 1'b0, 1'b0, "R1 8-bit field, bit 8 ignored");
      t_format(9'h1A5, 1'b1, 1'b0, 1'b0, "R1 9-bit field");
      t_format(9'h037, 1'b0, 1'b1, 1'b0, "R2 even parity 8-bit");
      t_format(9'h037, 1'b0, 1'b1, 1'b1, "R2 odd parity 8-bit");
      t_format(9'h0C1, 1'b1, 1'b1, 1'b0, "R2 even parity 9-bit");
      @(negedge clk); par_en = 1'b0; nine_bit = 1'b0;
      t_rate();
      t_div0();
      t_back_to_back();
      t_same_cycle();
      t_overwrite();
      t_enable();
      t_wired();
      finish_run();
   end
endmodule